// File: doc/BRIEF.md
# Scrambled-Map 64-Source Interrupt Controller

This block collects 64 active-low interrupt inputs and presents them to a bus master as a small set of 32-bit registers. Each source's pending and enable bits are placed in a high or a low word at a fixed bit position. That position comes from a fixed, irregular table rather than from the source number. A single `irq_out` line tells the CPU that at least one enabled source is pending. A vector register gives the number of the winning source.

Most sources are sensed as active-low levels. The external pins (sources 19 to 25) and the port pins (sources 48 to 63) can each be switched to falling-edge capture through an edge-select register. Software acknowledges a pending bit by writing a 1 to it. Sources 0 and 31 are reserved. Vector value 0 means "nothing pending", and source 31 would share low-word bit 0 with source 18.

The bus side is a single-cycle register port. A write happens on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `scram_irq_ctrl`

## Requirements
- R1: Source placement. The high word holds sources 1–15 at bits 15..1 (bit = 16−N) and sources 32–47 at bits 31..16 (bit = 63−N). The low word holds sources 16–18 at bits 2..0 (bit = 18−N), sources 19–30 at bits 14..3 (bit = 33−N) and sources 48–63 at bits 16..31 (bit = N−32).
- R2: Register addresses are: 0 mask high, 1 mask low, 2 pending high, 3 pending low, 4 edge select, 5 vector. Other addresses read 0. Both mask words reset to 0 and read back what was written. A mask bit of 1 enables the source at that position.
- R3: A level-sensed source's pending bit equals its inverted input one clock after the input is sampled. A write-one-to-clear does not clear it while the input stays low.
- R4: The edge-select bit for source N is at 33−N for N in 19–25 and at 79−N for N in 48–63. All other edge-select bits are fixed at 0, so writing all ones reads back 0xFFFF7F00. The register resets to 0.
- R5: A source whose edge-select bit is 1 sets its pending bit on a falling input edge. The bit stays set after the input returns high. A rising edge does not set it.
- R6: Writing a 1 to a pending-register bit clears that pending bit. Writing a 0 leaves the bit unchanged.
- R7: If a write-one-to-clear and a new falling edge on an edge-sensed source fall in the same cycle, the pending bit stays set.
- R8: `irq_out` is 1 exactly when some pending bit has its mask bit set. Masked pending bits still read as pending.
- R9: The vector register holds, in bits 31:26, the lowest-numbered source that is both pending and enabled. Its other bits are 0, and the field is 0 when no such source exists. Reading it changes nothing.
- R10: Sources 0 and 31 never become pending and never drive `irq_out` or the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_n | input | 64 | Interrupt inputs, active low, index = source number |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with its default values: 64 sources, 32-bit words and a 3-bit address. These values bring every irregular region of the placement table within reach, including the bit-0 collision between sources 18 and 31. They also let one register write both acknowledge and re-arm an edge source. The directed tests cover the corner sources of each region, level clears that fail while the input is held low, edge capture against a same-cycle acknowledge, and priority changes as masks are withdrawn.

// File: rtl/ic_map_pkg.sv
package ic_map_pkg;

    // 1 when the source lives in the high word
    function automatic bit src_in_high(input int n);
        return (n < 16) || (n >= 32 && n < 48);
    endfunction

    // bit position of the source inside its word
    function automatic int src_bit(input int n);
        if (n == 0)       return 0;
        else if (n < 16)  return 16 - n;
        else if (n < 19)  return 18 - n;
        else if (n < 31)  return 33 - n;
        else if (n == 31) return 0;
        else if (n < 48)  return 63 - n;
        else              return n - 32;
    endfunction

    function automatic bit src_reserved(input int n);
        return (n == 0) || (n == 31);
    endfunction

    function automatic bit edge_capable(input int n);
        return (n >= 19 && n <= 25) || (n >= 48 && n <= 63);
    endfunction

    function automatic int edge_bit(input int n);
        if (n <= 25) return 33 - n;
        else         return 79 - n;
    endfunction

    function automatic logic [31:0] edge_wmask();
        logic [31:0] m;
        m = '0;
        for (int n = 0; n < 64; n++)
            if (edge_capable(n)) m[edge_bit(n)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ic_src_sense.sv
module ic_src_sense (
    input  logic clk,
    input  logic rst,
    input  logic src_n,
    input  logic edge_mode,
    input  logic clr,
    output logic pend
);
    logic prev_n;
    logic fall;

    assign fall = prev_n & ~src_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_n <= 1'b1;
            pend   <= 1'b0;
        end else begin
            prev_n <= src_n;
            if (edge_mode)
                pend <= (pend & ~clr) | fall;
            else
                pend <= ~src_n;
        end
    end

    // R3: a held-low level source cannot be cleared
    a_r3_level_held: assert property (@(posedge clk) disable iff (rst)
        (!edge_mode && !src_n) |=> pend);

    // R5: an edge-captured bit stays until acknowledged
    a_r5_edge_hold: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && pend && !clr) |=> pend);

    // R7: a new edge wins over a same-cycle acknowledge
    a_r7_no_lost_edge: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && clr && fall) |=> pend);

endmodule

// File: rtl/ic_vec_enc.sv
module ic_vec_enc #(
    parameter int NSRC = 64,
    localparam int VW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] act,
    output logic [VW-1:0]   vec
);
    always_comb begin
        vec = '0;
        for (int n = NSRC - 1; n >= 1; n--)
            if (act[n]) vec = VW'(n);
    end
endmodule

// File: rtl/scram_irq_ctrl.sv
module scram_irq_ctrl
    import ic_map_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int DW   = 32,
    parameter int AW   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_out
);
    localparam int VW = $clog2(NSRC);
    localparam logic [AW-1:0] ADR_MASK_HI = AW'(0);
    localparam logic [AW-1:0] ADR_MASK_LO = AW'(1);
    localparam logic [AW-1:0] ADR_PEND_HI = AW'(2);
    localparam logic [AW-1:0] ADR_PEND_LO = AW'(3);
    localparam logic [AW-1:0] ADR_EDGE    = AW'(4);
    localparam logic [AW-1:0] ADR_VEC     = AW'(5);
    localparam logic [DW-1:0] EDGE_WM     = DW'(edge_wmask());

    logic [DW-1:0]   mask_hi, mask_lo, edge_q;
    logic [DW-1:0]   pend_hi, pend_lo;
    logic [NSRC-1:0] pend_raw, pend_eff, mask_src, act;
    logic [VW-1:0]   vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_hi <= '0;
            mask_lo <= '0;
            edge_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADR_MASK_HI) mask_hi <= bus_wdata;
            if (bus_addr == ADR_MASK_LO) mask_lo <= bus_wdata;
            if (bus_addr == ADR_EDGE)    edge_q  <= bus_wdata & EDGE_WM;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam bit HI = src_in_high(i);
        localparam int BP = src_bit(i);
        logic em, clr;
        if (edge_capable(i)) begin : g_edge
            assign em = edge_q[edge_bit(i)];
        end else begin : g_level
            assign em = 1'b0;
        end
        assign clr = bus_wr && (bus_addr == (HI ? ADR_PEND_HI : ADR_PEND_LO))
                     && bus_wdata[BP];
        ic_src_sense u_sense (
            .clk(clk), .rst(rst), .src_n(src_n[i]),
            .edge_mode(em), .clr(clr), .pend(pend_raw[i])
        );
        assign pend_eff[i] = pend_raw[i] & ~src_reserved(i);
        assign mask_src[i] = HI ? mask_hi[BP] : mask_lo[BP];
    end

    always_comb begin
        pend_hi = '0;
        pend_lo = '0;
        for (int n = 0; n < NSRC; n++) begin
            if (src_in_high(n)) pend_hi[src_bit(n)] = pend_hi[src_bit(n)] | pend_eff[n];
            else                pend_lo[src_bit(n)] = pend_lo[src_bit(n)] | pend_eff[n];
        end
    end

    assign act     = pend_eff & mask_src;
    assign irq_out = |act;

    ic_vec_enc #(.NSRC(NSRC)) u_vec (.act(act), .vec(vec));

    always_comb begin
        unique case (bus_addr)
            ADR_MASK_HI: bus_rdata = mask_hi;
            ADR_MASK_LO: bus_rdata = mask_lo;
            ADR_PEND_HI: bus_rdata = pend_hi;
            ADR_PEND_LO: bus_rdata = pend_lo;
            ADR_EDGE:    bus_rdata = edge_q;
            ADR_VEC:     bus_rdata = {vec, {(DW-VW){1'b0}}};
            default:     bus_rdata = '0;
        endcase
    end

    // R2: masks come out of reset cleared
    a_r2_mask_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_hi == '0 && mask_lo == '0));

    // R8: request line agrees with the vector encoder
    a_r8_irq_vs_vec: assert property (@(posedge clk) disable iff (rst)
        irq_out == (vec != '0));

    // R9: a reported vector names an active source
    a_r9_vec_active: assert property (@(posedge clk) disable iff (rst)
        (vec != '0) |-> act[vec]);

    // R10: reserved sources never reach the vector
    a_r10_reserved_out: assert property (@(posedge clk) disable iff (rst)
        vec != VW'(31));

endmodule

// File: tb/tb_scram_irq_ctrl.sv
module tb_scram_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_n = '1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    int total = 0;
    int bad = 0;

    scram_irq_ctrl dut (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    function automatic bit exp_hi(input int n);
        return (n < 16) || (n >= 32 && n < 48);
    endfunction

    function automatic int exp_pos(input int n);
        if (n < 16) return 16 - n;
        if (n < 19) return 18 - n;
        if (n < 31) return 33 - n;
        if (n < 48) return 63 - n;
        return n - 32;
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        rd(3'd0, d); chk("R2 mask_hi reset", d, 32'h0);
        rd(3'd1, d); chk("R2 mask_lo reset", d, 32'h0);
        rd(3'd4, d); chk("R4 edge reset", d, 32'h0);
        rd(3'd5, d); chk("R9 vec reset", d, 32'h0);
        chk("R8 irq reset", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_mask_rw;
        logic [31:0] d;
        wr(3'd0, 32'hA5A5_5A5A); wr(3'd1, 32'h0F0F_F0F0);
        rd(3'd0, d); chk("R2 mask_hi rw", d, 32'hA5A5_5A5A);
        rd(3'd1, d); chk("R2 mask_lo rw", d, 32'h0F0F_F0F0);
        rd(3'd6, d); chk("R2 unused addr", d, 32'h0);
    endtask

    task automatic t_map;
        int list [10] = '{1, 15, 16, 18, 19, 30, 32, 47, 48, 63};
        logic [31:0] dh, dl;
        foreach (list[k]) begin
            int n = list[k];
            @(negedge clk); src_n[n] = 1'b0;
            @(negedge clk);
            rd(3'd2, dh); rd(3'd3, dl);
            chk($sformatf("R1 src %0d hi", n), dh, exp_hi(n) ? (32'h1 << exp_pos(n)) : 32'h0);
            chk($sformatf("R1 src %0d lo", n), dl, exp_hi(n) ? 32'h0 : (32'h1 << exp_pos(n)));
            src_n[n] = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic t_level;
        logic [31:0] d;
        wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
        @(negedge clk); src_n[5] = 1'b0;
        @(negedge clk);
        rd(3'd2, d); chk("R3 level pend", d, 32'h1 << 11);
        chk("R8 irq level", {31'b0, irq_out}, 32'h1);
        wr(3'd2, 32'h1 << 11);
        rd(3'd2, d); chk("R3 clear while held", d, 32'h1 << 11);
        rd(3'd5, d); chk("R9 vec 5", d, 32'd5 << 26);
        rd(3'd5, d); chk("R9 vec read no side effect", d, 32'd5 << 26);
        src_n[5] = 1'b1;
        @(negedge clk);
        rd(3'd2, d); chk("R3 level release", d, 32'h0);
        chk("R8 irq off", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_priority;
        logic [31:0] d;
        @(negedge clk); src_n[40] = 1'b0; src_n[20] = 1'b0;
        @(negedge clk);
        rd(3'd5, d); chk("R9 lowest wins", d, 32'd20 << 26);
        wr(3'd1, ~(32'h1 << 13));
        rd(3'd5, d); chk("R9 masked skipped", d, 32'd40 << 26);
        wr(3'd0, ~(32'h1 << 23));
        rd(3'd5, d); chk("R9 none enabled", d, 32'h0);
        chk("R8 irq masked", {31'b0, irq_out}, 32'h0);
        rd(3'd2, d); chk("R8 masked still pending", d, 32'h1 << 23);
        src_n[40] = 1'b1; src_n[20] = 1'b1;
        wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
    endtask

    task automatic t_edge;
        logic [31:0] d;
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, d); chk("R4 edge writable bits", d, 32'hFFFF_7F00);
        wr(3'd4, (32'h1 << 12) | (32'h1 << 29));
        rd(3'd4, d); chk("R4 edge readback", d, (32'h1 << 12) | (32'h1 << 29));
        @(negedge clk); src_n[21] = 1'b0;
        @(negedge clk); src_n[21] = 1'b1;
        @(negedge clk);
        rd(3'd3, d); chk("R5 edge held", d, 32'h1 << 12);
        wr(3'd3, 32'h0);
        rd(3'd3, d); chk("R6 write zero keeps", d, 32'h1 << 12);
        wr(3'd3, 32'h1 << 12);
        rd(3'd3, d); chk("R6 write one clears", d, 32'h0);
        @(negedge clk); src_n[21] = 1'b0;
        wr(3'd3, 32'h1 << 12);
        @(negedge clk); src_n[21] = 1'b1;
        @(negedge clk);
        rd(3'd3, d); chk("R5 rising no effect", d, 32'h0);
    endtask

    task automatic t_collision;
        logic [31:0] d;
        @(negedge clk); src_n[50] = 1'b0;
        @(negedge clk); src_n[50] = 1'b1;
        @(negedge clk);
        rd(3'd3, d); chk("R5 port edge", d, 32'h1 << 18);
        bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h1 << 18; src_n[50] = 1'b0;
        @(negedge clk); bus_wr = 1'b0;
        rd(3'd3, d); chk("R7 clear with new edge", d, 32'h1 << 18);
        src_n[50] = 1'b1;
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, d); chk("R6 clear all", d, 32'h0);
    endtask

    task automatic t_reserved;
        logic [31:0] d;
        wr(3'd4, 32'h0);
        @(negedge clk); src_n[0] = 1'b0; src_n[31] = 1'b0;
        @(negedge clk);
        rd(3'd2, d); chk("R10 src0 hi", d, 32'h0);
        rd(3'd3, d); chk("R10 src31 lo", d, 32'h0);
        rd(3'd5, d); chk("R10 vec", d, 32'h0);
        chk("R10 irq", {31'b0, irq_out}, 32'h0);
        src_n[0] = 1'b1; src_n[31] = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mask_rw();
        t_map();
        t_level();
        t_priority();
        t_edge();
        t_collision();
        t_reserved();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule